// File: doc/BRIEF.md
# DMA Channel Register Front End

This block is the byte-wide host side of a four-channel DMA controller. Software reaches each channel's 16-bit start address and 16-bit transfer count through a single 8-bit port per register. An internal byte pointer chooses the low or the high half on each access. Each write lands in both a base copy and a working copy of the register. Reads return the working copy, which a separate transfer engine may rewrite as it runs. The count holds the number of transfers less one: 0x0000 stands for one transfer and 0xFFFF for 65536.

The same port space also carries the control ports. These are a command latch, a status read, a software request bit per channel, a per-channel mask, a per-channel mode field, and a clear for the byte pointer. A master clear, a clear for all masks and a write for all masks complete the set. The block holds all of this state and drives it out to the transfer engine. The engine in turn reports terminal counts and rewrites working registers through a small update port. The parameter `OFFS_SHIFT` scales every port offset by a power of two, so one design serves both a byte-wide instance and a word-wide instance whose offsets are doubled.

Top module: `dmac_host_regs`

## Requirements
- R1: After reset all four masks are set, the byte pointer points at the low byte, and the command, request and terminal-count state is zero. All address and count registers are zero.
- R2: Port index `offs >> OFFS_SHIFT` selects the register: channel n's address is at index 2n and its count at index 2n+1. An access whose offset has any of its low `OFFS_SHIFT` bits set is ignored and does not move the pointer.
- R3: Every byte read or write to an address or count port uses the low byte when the pointer is clear and the high byte when it is set, and then toggles the pointer.
- R4: Any write to control index 0xC forces the byte pointer to the low state.
- R5: A write to an address or count port stores the byte in both the base and the working copy. A read returns the working copy. An engine update (`upd_en`) changes only the working copies of the channel given by `upd_chan`.
- R6: A write to index 0xA uses data bits [1:0] as the channel. Bit 2 set masks that channel and bit 2 clear unmasks it.
- R7: A write to index 0xB uses data bits [1:0] as the channel and stores data bits [7:2] as that channel's 6-bit mode field. Byte 0x44 therefore gives field 0x11, byte 0x48 gives 0x12, byte 0xC0 gives 0x30, and the auto-initialize bit 4 of the byte lands in field bit 2.
- R8: A write to index 0xE clears all masks. A write to index 0xF loads data bits [3:0] as the masks, with bit n for channel n.
- R9: A write to index 0x8 loads the command byte. A read of index 0x8 returns status with the request bits in [7:4] and the terminal-count flags in [3:0]. A `tc_in` bit sets its flag, and a status read clears the flags except those raised in the same cycle.
- R10: A write to index 0x9 uses data bits [1:0] as the channel. Bit 2 sets that channel's software request and bit 2 clear resets it.
- R11: A write to index 0xD (master clear) sets all masks, clears the pointer and clears the command, request and terminal-count state. Address, count and mode registers keep their values. A read of index 0xD returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Port access select |
| wr_en | input | 1 | Write strobe (wins over read) |
| rd_en | input | 1 | Read strobe |
| offs | input | 4+OFFS_SHIFT | Port offset |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte (combinational) |
| tc_in | input | 4 | Terminal-count pulses from the engine |
| upd_en | input | 1 | Engine rewrite of working registers |
| upd_chan | input | 2 | Channel of the engine rewrite |
| upd_addr | input | 16 | New working address |
| upd_cnt | input | 16 | New working count |
| chan_mask | output | 4 | Mask bit per channel |
| chan_mode | output | 24 | 6-bit mode field per channel, channel n at [6n+5:6n] |
| cmd_reg | output | 8 | Command byte |
| sw_req | output | 4 | Software request per channel |
| base_addr | output | 64 | Base address, channel n at [16n+15:16n] |
| cur_addr | output | 64 | Working address, same layout |
| base_cnt | output | 64 | Base count, same layout |
| cur_cnt | output | 64 | Working count, same layout |

## Verification
The bench builds the block with `OFFS_SHIFT` = 1, the word-wide layout in which every port sits at twice its index. This makes odd offsets reachable, so the bench can show that such accesses are dropped and leave both the registers and the pointer alone. The same setting still exercises the full index decode, covering the pointer sequence across reads and writes, the dual base and working copies, and all of the mask, mode, request and master-clear ports.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int NCH    = 4;
    localparam int CHW    = $clog2(NCH);
    localparam int RW     = 16;
    localparam int MODE_W = 6;

    // Control port indices (above the channel register window)
    localparam logic [3:0] IDX_CMD     = 4'h8;
    localparam logic [3:0] IDX_REQ     = 4'h9;
    localparam logic [3:0] IDX_MASK1   = 4'hA;
    localparam logic [3:0] IDX_MODE    = 4'hB;
    localparam logic [3:0] IDX_CLRPTR  = 4'hC;
    localparam logic [3:0] IDX_MCLR    = 4'hD;
    localparam logic [3:0] IDX_CLRMSK  = 4'hE;
    localparam logic [3:0] IDX_MASKALL = 4'hF;

    typedef struct packed {
        logic           wr;
        logic           rd;
        logic           reg_acc;
        logic           is_cnt;
        logic [CHW-1:0] chan;
        logic           wr_cmd;
        logic           wr_req;
        logic           wr_mask;
        logic           wr_mode;
        logic           wr_clrptr;
        logic           wr_mclr;
        logic           wr_clrmsk;
        logic           wr_maskall;
        logic           rd_status;
    } dec_t;

    typedef struct packed {
        logic [RW-1:0] base_addr;
        logic [RW-1:0] cur_addr;
        logic [RW-1:0] base_cnt;
        logic [RW-1:0] cur_cnt;
    } chan_t;

    typedef struct packed {
        logic                         ptr;
        logic [NCH-1:0]               mask;
        logic [NCH-1:0][MODE_W-1:0]   mode;
        logic [7:0]                   cmd;
        logic [NCH-1:0]               req;
        logic [NCH-1:0]               tc;
    } ctl_t;
endpackage

// File: rtl/dmac_port_decode.sv
module dmac_port_decode
    import dmac_pkg::*;
#(
    parameter int OFFS_SHIFT = 0,
    localparam int OW = 4 + OFFS_SHIFT
) (
    input  logic          sel,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [OW-1:0] offs,
    output dec_t          dec
);
    logic       aligned;
    logic [3:0] idx;
    logic       wr;
    logic       rd;

    generate
        if (OFFS_SHIFT == 0) begin : g_noscale
            assign aligned = 1'b1;
        end else begin : g_scale
            assign aligned = (offs[OFFS_SHIFT-1:0] == '0);
        end
    endgenerate

    assign idx = offs[OW-1:OFFS_SHIFT];
    assign wr  = sel && wr_en && aligned;
    assign rd  = sel && rd_en && !wr_en && aligned;

    always_comb begin
        dec      = '0;
        dec.wr   = wr;
        dec.rd   = rd;
        dec.chan = idx[CHW:1];
        if (!idx[3]) begin
            dec.reg_acc = wr || rd;
            dec.is_cnt  = idx[0];
        end else begin
            case (idx)
                IDX_CMD: begin
                    dec.wr_cmd    = wr;
                    dec.rd_status = rd;
                end
                IDX_REQ:     dec.wr_req     = wr;
                IDX_MASK1:   dec.wr_mask    = wr;
                IDX_MODE:    dec.wr_mode    = wr;
                IDX_CLRPTR:  dec.wr_clrptr  = wr;
                IDX_MCLR:    dec.wr_mclr    = wr;
                IDX_CLRMSK:  dec.wr_clrmsk  = wr;
                IDX_MASKALL: dec.wr_maskall = wr;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
    import dmac_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_addr,
    input  logic          wr_cnt,
    input  logic          hi_byte,
    input  logic [7:0]    wdata,
    input  logic          upd_en,
    input  logic [RW-1:0] upd_addr,
    input  logic [RW-1:0] upd_cnt,
    output logic [RW-1:0] base_addr,
    output logic [RW-1:0] cur_addr,
    output logic [RW-1:0] base_cnt,
    output logic [RW-1:0] cur_cnt
);
    chan_t ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;
        if (upd_en) begin
            ch_d.cur_addr = upd_addr;
            ch_d.cur_cnt  = upd_cnt;
        end
        // host byte write lands in base and working copy alike
        if (wr_addr) begin
            if (hi_byte) begin
                ch_d.base_addr[15:8] = wdata;
                ch_d.cur_addr[15:8]  = wdata;
            end else begin
                ch_d.base_addr[7:0]  = wdata;
                ch_d.cur_addr[7:0]   = wdata;
            end
        end
        if (wr_cnt) begin
            if (hi_byte) begin
                ch_d.base_cnt[15:8] = wdata;
                ch_d.cur_cnt[15:8]  = wdata;
            end else begin
                ch_d.base_cnt[7:0]  = wdata;
                ch_d.cur_cnt[7:0]   = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign base_addr = ch_q.base_addr;
    assign cur_addr  = ch_q.cur_addr;
    assign base_cnt  = ch_q.base_cnt;
    assign cur_cnt   = ch_q.cur_cnt;
endmodule

// File: rtl/dmac_host_regs.sv
module dmac_host_regs
    import dmac_pkg::*;
#(
    parameter int OFFS_SHIFT = 0,
    localparam int OW = 4 + OFFS_SHIFT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [OW-1:0]         offs,
    input  logic [7:0]            wdata,
    output logic [7:0]            rdata,
    input  logic [NCH-1:0]        tc_in,
    input  logic                  upd_en,
    input  logic [CHW-1:0]        upd_chan,
    input  logic [RW-1:0]         upd_addr,
    input  logic [RW-1:0]         upd_cnt,
    output logic [NCH-1:0]        chan_mask,
    output logic [NCH*MODE_W-1:0] chan_mode,
    output logic [7:0]            cmd_reg,
    output logic [NCH-1:0]        sw_req,
    output logic [NCH*RW-1:0]     base_addr,
    output logic [NCH*RW-1:0]     cur_addr,
    output logic [NCH*RW-1:0]     base_cnt,
    output logic [NCH*RW-1:0]     cur_cnt
);
    dec_t dec;
    ctl_t ctl_d, ctl_q;

    dmac_port_decode #(.OFFS_SHIFT(OFFS_SHIFT)) i_dec (
        .sel   (sel),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .offs  (offs),
        .dec   (dec)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            dmac_chan_regs i_ch (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_addr   (dec.wr && dec.reg_acc && !dec.is_cnt && dec.chan == CHW'(c)),
                .wr_cnt    (dec.wr && dec.reg_acc &&  dec.is_cnt && dec.chan == CHW'(c)),
                .hi_byte   (ctl_q.ptr),
                .wdata     (wdata),
                .upd_en    (upd_en && upd_chan == CHW'(c)),
                .upd_addr  (upd_addr),
                .upd_cnt   (upd_cnt),
                .base_addr (base_addr[c*RW +: RW]),
                .cur_addr  (cur_addr[c*RW +: RW]),
                .base_cnt  (base_cnt[c*RW +: RW]),
                .cur_cnt   (cur_cnt[c*RW +: RW])
            );
        end
    endgenerate

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.tc = ctl_q.tc | tc_in;
        if (dec.reg_acc)   ctl_d.ptr = !ctl_q.ptr;
        if (dec.wr_clrptr) ctl_d.ptr = 1'b0;
        if (dec.wr_mask)   ctl_d.mask[wdata[CHW-1:0]] = wdata[2];
        if (dec.wr_mode)   ctl_d.mode[wdata[CHW-1:0]] = wdata[7:2];
        if (dec.wr_req)    ctl_d.req[wdata[CHW-1:0]]  = wdata[2];
        if (dec.wr_cmd)    ctl_d.cmd  = wdata;
        if (dec.wr_clrmsk) ctl_d.mask = '0;
        if (dec.wr_maskall) ctl_d.mask = wdata[NCH-1:0];
        if (dec.rd_status) ctl_d.tc   = tc_in;
        if (dec.wr_mclr) begin
            ctl_d.mask = '1;
            ctl_d.ptr  = 1'b0;
            ctl_d.cmd  = '0;
            ctl_d.req  = '0;
            ctl_d.tc   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.mask <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // read path: working copy of the selected register, byte by pointer
    logic [RW-1:0] rd_word;
    always_comb begin
        rd_word = dec.is_cnt ? cur_cnt[dec.chan*RW +: RW] : cur_addr[dec.chan*RW +: RW];
        rdata   = '0;
        if (dec.rd && dec.reg_acc) rdata = ctl_q.ptr ? rd_word[15:8] : rd_word[7:0];
        else if (dec.rd_status)    rdata = {ctl_q.req, ctl_q.tc};
    end

    assign chan_mask = ctl_q.mask;
    assign chan_mode = ctl_q.mode;
    assign cmd_reg   = ctl_q.cmd;
    assign sw_req    = ctl_q.req;

    // taps for the bound checker
    logic ptr_now, acc_now, clrptr_now, mclr_now, clrmsk_now, mask_now, wr_now;
    assign ptr_now    = ctl_q.ptr;
    assign acc_now    = dec.reg_acc;
    assign clrptr_now = dec.wr_clrptr;
    assign mclr_now   = dec.wr_mclr;
    assign clrmsk_now = dec.wr_clrmsk;
    assign mask_now   = dec.wr_mask;
    assign wr_now     = dec.wr;
endmodule

// File: rtl/dmac_host_regs_chk.sv
module dmac_host_regs_chk
    import dmac_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ptr_now,
    input logic              acc_now,
    input logic              clrptr_now,
    input logic              mclr_now,
    input logic              clrmsk_now,
    input logic              mask_now,
    input logic              wr_now,
    input logic              upd_en,
    input logic [7:0]        wdata,
    input logic [NCH-1:0]    chan_mask,
    input logic [7:0]        cmd_reg,
    input logic [NCH*RW-1:0] base_addr
);
    p_ptr_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_now |=> ptr_now != $past(ptr_now));

    p_ptr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clrptr_now |=> !ptr_now);

    p_base_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !wr_now) |=> $stable(base_addr));

    p_single_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mask_now |=> chan_mask[$past(wdata[CHW-1:0])] == $past(wdata[2]));

    p_clear_masks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clrmsk_now |=> chan_mask == '0);

    p_master_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mclr_now |=> (chan_mask == '1 && cmd_reg == 8'h00 && !ptr_now));
endmodule

bind dmac_host_regs dmac_host_regs_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ptr_now    (ptr_now),
    .acc_now    (acc_now),
    .clrptr_now (clrptr_now),
    .mclr_now   (mclr_now),
    .clrmsk_now (clrmsk_now),
    .mask_now   (mask_now),
    .wr_now     (wr_now),
    .upd_en     (upd_en),
    .wdata      (wdata),
    .chan_mask  (chan_mask),
    .cmd_reg    (cmd_reg),
    .base_addr  (base_addr)
);

// File: tb/test_dmac_host_regs.sv
module test_dmac_host_regs;
    localparam int SH = 1;
    localparam int OW = 4 + SH;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [OW-1:0] offs = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic [3:0]    tc_in = '0;
    logic          upd_en = 1'b0;
    logic [1:0]    upd_chan = '0;
    logic [15:0]   upd_addr = '0, upd_cnt = '0;
    logic [3:0]    chan_mask, sw_req;
    logic [23:0]   chan_mode;
    logic [7:0]    cmd_reg;
    logic [63:0]   base_addr, cur_addr, base_cnt, cur_cnt;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dmac_host_regs #(.OFFS_SHIFT(SH)) i_dmac_host_regs (
        .clk, .rst_n, .sel, .wr_en, .rd_en, .offs, .wdata, .rdata,
        .tc_in, .upd_en, .upd_chan, .upd_addr, .upd_cnt,
        .chan_mask, .chan_mode, .cmd_reg, .sw_req,
        .base_addr, .cur_addr, .base_cnt, .cur_cnt
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [OW-1:0] o, input logic [7:0] d);
        sel = 1'b1; wr_en = 1'b1; offs = o; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [OW-1:0] o, input logic [7:0] e, input string tag);
        sel = 1'b1; rd_en = 1'b1; offs = o;
        #1;
        check(tag, 32'(rdata), 32'(e));
        @(negedge clk);
        sel = 1'b0; rd_en = 1'b0;
    endtask

    // {read, offset, data-or-expected}; ports are at index*2
    localparam int NV = 28;
    localparam logic [13:0] VEC [NV] = '{
        {1'b0, 5'h18, 8'h00},
        {1'b0, 5'h04, 8'h34}, {1'b0, 5'h04, 8'h12},
        {1'b1, 5'h04, 8'h34}, {1'b1, 5'h04, 8'h12},
        {1'b0, 5'h06, 8'hFF}, {1'b0, 5'h06, 8'hFF},
        {1'b1, 5'h06, 8'hFF}, {1'b1, 5'h06, 8'hFF},
        {1'b0, 5'h00, 8'h01}, {1'b0, 5'h18, 8'h00},
        {1'b0, 5'h00, 8'hAA}, {1'b0, 5'h00, 8'hBB},
        {1'b1, 5'h00, 8'hAA}, {1'b1, 5'h00, 8'hBB},
        {1'b0, 5'h0C, 8'h00}, {1'b0, 5'h0C, 8'h80},
        {1'b1, 5'h0C, 8'h00}, {1'b1, 5'h0C, 8'h80},
        {1'b0, 5'h05, 8'h77},
        {1'b1, 5'h04, 8'h34}, {1'b1, 5'h04, 8'h12},
        {1'b1, 5'h10, 8'h00},
        {1'b0, 5'h12, 8'h06}, {1'b1, 5'h10, 8'h40},
        {1'b0, 5'h12, 8'h02}, {1'b1, 5'h10, 8'h00},
        {1'b1, 5'h1A, 8'h00}
    };

    initial begin
        #(8 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 masks", 32'(chan_mask), 32'hF);
        check("R1 cmd", 32'(cmd_reg), 32'h0);
        check("R1 base addr", base_addr[31:0], 32'h0);
        check("R1 req", 32'(sw_req), 32'h0);

        // R2 R3 R4 R5 R9 R10 R11 vector walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][13]) do_rd(VEC[i][12:8], VEC[i][7:0], "R2 R3 R5 R9 R10 R11 vector");
            else            do_wr(VEC[i][12:8], VEC[i][7:0]);
        end

        check("R5 base ch1 addr", 32'(base_addr[31:16]), 32'h1234);
        check("R5 cur ch1 cnt", 32'(cur_cnt[31:16]), 32'hFFFF);
        check("R4 ch0 addr after clear", 32'(base_addr[15:0]), 32'hBBAA);
        check("R2 ch3 addr", 32'(cur_addr[63:48]), 32'h8000);

        // R6 single mask, R8 clear/all masks
        do_wr(5'h14, 8'h01);
        check("R6 unmask ch1", 32'(chan_mask), 32'hD);
        do_wr(5'h14, 8'h05);
        check("R6 mask ch1", 32'(chan_mask), 32'hF);
        do_wr(5'h1C, 8'h00);
        check("R8 clear masks", 32'(chan_mask), 32'h0);
        do_wr(5'h1E, 8'h0A);
        check("R8 mask all", 32'(chan_mask), 32'hA);

        // R7 modes
        do_wr(5'h16, 8'h45);
        do_wr(5'h16, 8'hC3);
        do_wr(5'h16, 8'h5A);
        check("R7 mode ch1", 32'(chan_mode[11:6]), 32'h11);
        check("R7 mode ch3", 32'(chan_mode[23:18]), 32'h30);
        check("R7 mode ch2 autoinit", 32'(chan_mode[17:12]), 32'h16);
        check("R7 mode ch0 untouched", 32'(chan_mode[5:0]), 32'h00);

        // R9 command and terminal-count flags
        do_wr(5'h10, 8'h5C);
        check("R9 cmd", 32'(cmd_reg), 32'h5C);
        tc_in = 4'b1001;
        @(negedge clk);
        tc_in = 4'b0000;
        do_rd(5'h10, 8'h09, "R9 status tc");
        do_rd(5'h10, 8'h00, "R9 status cleared");

        // R5 engine update touches working copies only
        upd_en = 1'b1; upd_chan = 2'd1; upd_addr = 16'h1300; upd_cnt = 16'h00FE;
        @(negedge clk);
        upd_en = 1'b0;
        check("R5 cur addr updated", 32'(cur_addr[31:16]), 32'h1300);
        check("R5 base addr kept", 32'(base_addr[31:16]), 32'h1234);
        check("R5 base cnt kept", 32'(base_cnt[31:16]), 32'hFFFF);
        do_rd(5'h06, 8'hFE, "R5 read working count low");
        do_rd(5'h06, 8'h00, "R5 read working count high");

        // R11 master clear
        do_rd(5'h04, 8'h00, "R3 pointer low before clear");
        do_wr(5'h12, 8'h04);
        do_wr(5'h10, 8'h33);
        do_wr(5'h1A, 8'h00);
        check("R11 masks set", 32'(chan_mask), 32'hF);
        check("R11 cmd cleared", 32'(cmd_reg), 32'h0);
        check("R11 req cleared", 32'(sw_req), 32'h0);
        check("R11 base kept", 32'(base_addr[31:16]), 32'h1234);
        check("R11 mode kept", 32'(chan_mode[11:6]), 32'h11);
        do_rd(5'h04, 8'h00, "R11 pointer cleared");
        do_rd(5'h10, 8'h00, "R11 status cleared");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule